// File: doc/BRIEF.md
# Stable-Signature Hang Detector

This block watches a 32-bit baseband observation word and four 32-bit DMA debug words and decides whether the datapath behind them has locked up. A start request makes it take a reference snapshot of every word. It then re-reads the words once per clock over a fixed window. A group of words counts as hung only when every re-read equals the snapshot. A frozen snapshot is then sorted against a short list of known lock-up signatures and reported as a 3-bit code, with a one-cycle done pulse.

The baseband group is classified first. Its four masked patterns are tried in a fixed order. Only when the baseband group gives no hang is the MAC group tried. The MAC group has two signatures built from fields picked out of the DMA debug words. Two enable inputs, latched with the snapshot, choose which groups take part. A stable snapshot that matches no signature gives code 0 and raises a separate "frozen but unrecognised" flag.

Top module: `stall_sig_monitor`

## Requirements
- R1: After reset, `donePulse`, `hangCode` and `unknownStable` are all 0.
- R2: A start request seen while idle captures the reference on that clock edge (edge C). The next NUM_READS edges (default 50) each compare one sample. `donePulse` is high for exactly one cycle after edge C+NUM_READS+1.
- R3: A start request seen while a check is running is ignored. It neither restarts the window nor produces an extra done pulse.
- R4: If any compared sample of a group differs from its reference, that group reports no hang. This applies to the observation word for the baseband group and to any of debug words 3 to 6 for the MAC group. A difference in the last sample counts.
- R5: The baseband patterns are tried in this order, as (mask, value) pairs, and the first match wins. (0x7E000B00, 0x1E000000) gives code 1. (0x7E000B00, 0x52000B00) gives code 2. (0x7E000B00, 0x18000B00) gives code 3. (0x7E7FFFEF, 0x00702400) gives code 3. Bits outside a mask are ignored.
- R6: MAC signature 1 gives code 4. It needs bits [1:0] of debug word 6 equal to 1, and at least one chain field equal to 0x6. The chain fields are the six 5-bit fields of debug word 4 at bits [5i+4:5i] (i = 0..5) and the four 5-bit fields of debug word 5 at the same positions (i = 0..3).
- R7: MAC signature 2 gives code 5. It needs debug word 3 to hold bits [21:18] = 0x9, bits [25:22] = 0x8 and bits [28:26] = 0x4. When both MAC signatures match, code 4 wins.
- R8: A baseband hang suppresses the MAC result: its code is reported even if a MAC signature also matches.
- R9: A group whose enable (`bbCheckEn`, `macCheckEn`, sampled at the start edge) is low never produces a code, and changes on its words have no effect.
- R10: `unknownStable` is 1 at done exactly when the code is 0 and at least one enabled group stayed stable.
- R11: `hangCode` and `unknownStable` hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a check (taken only when idle) |
| bbCheckEn | input | 1 | Include the baseband group |
| macCheckEn | input | 1 | Include the MAC group |
| obsWord | input | 32 | Baseband observation word |
| dbgWord3 | input | 32 | DMA debug word 3 (queue states) |
| dbgWord4 | input | 32 | DMA debug word 4 (six chain fields) |
| dbgWord5 | input | 32 | DMA debug word 5 (four chain fields) |
| dbgWord6 | input | 32 | DMA debug word 6 (completion state) |
| donePulse | output | 1 | One-cycle end-of-check strobe |
| hangCode | output | 3 | 0 none, 1 DFS, 2 RIFS, 3 RX-clear, 4 MAC sig 1, 5 MAC sig 2 |
| unknownStable | output | 1 | Frozen group matched no signature |

## Verification
The assertions check several properties on every cycle. The window length stays bounded. Done is a single-cycle pulse. A lost stability flag stays lost until the next snapshot. The outputs hold between pulses. Only legal codes appear. The unknown flag comes only with code 0, and MAC codes appear only with the MAC group enabled. Whether a given word value decodes to the right code can only be shown by the bench scenarios: the priority among the baseband patterns, baseband suppression of MAC, the field positions of the chain states, and signature 1 winning over signature 2. The same holds for the exact cycle of the done pulse, a glitch on the last sample, and a start request ignored mid-window.

// File: rtl/stall_sig_pkg.sv
package stall_sig_pkg;

  localparam int WORD_W = 32;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic compare;
    logic publish;
  } strobe_t;

  typedef enum logic [2:0] {
    HC_NONE  = 3'd0,
    HC_DFS   = 3'd1,
    HC_RIFS  = 3'd2,
    HC_RXCLR = 3'd3,
    HC_MAC1  = 3'd4,
    HC_MAC2  = 3'd5
  } hang_code_e;

  localparam int BB_PATTERNS = 4;
  localparam logic [WORD_W-1:0] BB_MASK [BB_PATTERNS] =
    '{32'h7E00_0B00, 32'h7E00_0B00, 32'h7E00_0B00, 32'h7E7F_FFEF};
  localparam logic [WORD_W-1:0] BB_VALUE [BB_PATTERNS] =
    '{32'h1E00_0000, 32'h5200_0B00, 32'h1800_0B00, 32'h0070_2400};
  localparam hang_code_e BB_CODE [BB_PATTERNS] =
    '{HC_DFS, HC_RIFS, HC_RXCLR, HC_RXCLR};

endpackage

// File: rtl/stall_sig_ctrl.sv
module stall_sig_ctrl
  import stall_sig_pkg::*;
#(
  parameter int NUM_READS = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output strobe_t strobe
);

  localparam int CNT_W = $clog2(NUM_READS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_READS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_EVAL} state_e;

  state_e stateQ;
  logic [CNT_W-1:0] readCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      readCnt <= '0;
    end else begin
      unique case (stateQ)
        S_IDLE: if (startReq) begin
          stateQ  <= S_RUN;
          readCnt <= '0;
        end
        S_RUN: begin
          if (readCnt == LAST_IDX) stateQ <= S_EVAL;
          readCnt <= readCnt + 1'b1;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (stateQ == S_IDLE) && startReq;
    strobe.compare = (stateQ == S_RUN);
    strobe.publish = (stateQ == S_EVAL);
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_RUN) |-> (readCnt <= LAST_IDX)); // R2

  AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_RUN && readCnt != LAST_IDX) |=> (stateQ == S_RUN)); // R3

  AST_EVAL_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_EVAL) |=> (stateQ == S_IDLE)); // R2

endmodule

// File: rtl/stall_sig_datapath.sv
module stall_sig_datapath
  import stall_sig_pkg::*;
#(
  parameter int FIELD_W   = 5,
  parameter int FIELDS_D4 = 6,
  parameter int FIELDS_D5 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              bbCheckEn,
  input  logic              macCheckEn,
  input  logic [WORD_W-1:0] obsWord,
  input  logic [WORD_W-1:0] dbgWord3,
  input  logic [WORD_W-1:0] dbgWord4,
  input  logic [WORD_W-1:0] dbgWord5,
  input  logic [WORD_W-1:0] dbgWord6,
  output logic              donePulse,
  output logic [2:0]        hangCode,
  output logic              unknownStable
);

  localparam int CHAIN_FIELDS = FIELDS_D4 + FIELDS_D5;
  localparam logic [FIELD_W-1:0] CHAIN_HUNG = FIELD_W'(6);

  logic [WORD_W-1:0] refObs, ref3, ref4, ref5, ref6;
  logic bbEnQ, macEnQ, bbStableQ, macStableQ;

  // snapshot and stability tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refObs <= '0; ref3 <= '0; ref4 <= '0; ref5 <= '0; ref6 <= '0;
      bbEnQ <= 1'b0; macEnQ <= 1'b0;
      bbStableQ <= 1'b0; macStableQ <= 1'b0;
    end else if (strobe.capture) begin
      refObs <= obsWord;
      ref3 <= dbgWord3; ref4 <= dbgWord4; ref5 <= dbgWord5; ref6 <= dbgWord6;
      bbEnQ <= bbCheckEn; macEnQ <= macCheckEn;
      bbStableQ <= 1'b1; macStableQ <= 1'b1;
    end else if (strobe.compare) begin
      if (obsWord != refObs) bbStableQ <= 1'b0;
      if ((dbgWord3 != ref3) || (dbgWord4 != ref4) ||
          (dbgWord5 != ref5) || (dbgWord6 != ref6)) macStableQ <= 1'b0;
    end
  end

  // chain-state fields
  logic [CHAIN_FIELDS-1:0] chainHit;
  for (genvar i = 0; i < FIELDS_D4; i++) begin : g_d4
    assign chainHit[i] = (ref4[FIELD_W*i +: FIELD_W] == CHAIN_HUNG);
  end
  for (genvar i = 0; i < FIELDS_D5; i++) begin : g_d5
    assign chainHit[FIELDS_D4 + i] = (ref5[FIELD_W*i +: FIELD_W] == CHAIN_HUNG);
  end

  logic macSig1, macSig2;
  assign macSig1 = (|chainHit) && (ref6[1:0] == 2'h1);
  assign macSig2 = (ref3[21:18] == 4'h9) && (ref3[25:22] == 4'h8) &&
                   (ref3[28:26] == 3'h4);

  // baseband priority match, first entry wins
  hang_code_e bbCode;
  logic bbHit;
  always_comb begin
    bbCode = HC_NONE;
    bbHit  = 1'b0;
    for (int k = BB_PATTERNS - 1; k >= 0; k--) begin
      if ((refObs & BB_MASK[k]) == BB_VALUE[k]) begin
        bbCode = BB_CODE[k];
        bbHit  = 1'b1;
      end
    end
  end

  logic bbLive, macLive;
  hang_code_e nextCode;
  assign bbLive  = bbEnQ && bbStableQ;
  assign macLive = macEnQ && macStableQ;

  always_comb begin
    if (bbLive && bbHit)         nextCode = bbCode;
    else if (macLive && macSig1) nextCode = HC_MAC1;
    else if (macLive && macSig2) nextCode = HC_MAC2;
    else                         nextCode = HC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePulse     <= 1'b0;
      hangCode      <= 3'd0;
      unknownStable <= 1'b0;
    end else begin
      donePulse <= strobe.publish;
      if (strobe.publish) begin
        hangCode      <= nextCode;
        unknownStable <= (nextCode == HC_NONE) && (bbLive || macLive);
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R2

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (hangCode <= 3'd5)); // R5

  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && unknownStable) |-> (hangCode == 3'd0)); // R10

  AST_MAC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && hangCode >= 3'd4) |-> macEnQ); // R9

  AST_STABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !bbStableQ) |=> !bbStableQ); // R4

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> ($stable(hangCode) && $stable(unknownStable))); // R11

endmodule

// File: rtl/stall_sig_monitor.sv
module stall_sig_monitor
  import stall_sig_pkg::*;
#(
  parameter int NUM_READS = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        bbCheckEn,
  input  logic        macCheckEn,
  input  logic [31:0] obsWord,
  input  logic [31:0] dbgWord3,
  input  logic [31:0] dbgWord4,
  input  logic [31:0] dbgWord5,
  input  logic [31:0] dbgWord6,
  output logic        donePulse,
  output logic [2:0]  hangCode,
  output logic        unknownStable
);

  strobe_t strobe;

  stall_sig_ctrl #(.NUM_READS(NUM_READS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobe   (strobe)
  );

  stall_sig_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .bbCheckEn     (bbCheckEn),
    .macCheckEn    (macCheckEn),
    .obsWord       (obsWord),
    .dbgWord3      (dbgWord3),
    .dbgWord4      (dbgWord4),
    .dbgWord5      (dbgWord5),
    .dbgWord6      (dbgWord6),
    .donePulse     (donePulse),
    .hangCode      (hangCode),
    .unknownStable (unknownStable)
  );

endmodule

// File: tb/sim_stall_sig_monitor.sv
module sim_stall_sig_monitor;

  localparam int NREADS = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, bbCheckEn = 1'b0, macCheckEn = 1'b0;
  logic [31:0] obsWord = '0, dbgWord3 = '0, dbgWord4 = '0, dbgWord5 = '0, dbgWord6 = '0;
  logic donePulse, unknownStable;
  logic [2:0] hangCode;

  int cyc = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  int qCode[$], qUnk[$], qCyc[$];
  string qTag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stall_sig_monitor #(.NUM_READS(NREADS)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .bbCheckEn(bbCheckEn), .macCheckEn(macCheckEn),
    .obsWord(obsWord), .dbgWord3(dbgWord3), .dbgWord4(dbgWord4),
    .dbgWord5(dbgWord5), .dbgWord6(dbgWord6),
    .donePulse(donePulse), .hangCode(hangCode), .unknownStable(unknownStable)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected item at each done pulse
  always @(negedge clk) begin
    if (rstN && donePulse) begin
      if (qCode.size() == 0) begin
        check(1'b0, "R3", "unexpected done pulse", 1, 0);
      end else begin
        int eCode, eUnk, eCyc;
        string tag;
        eCode = qCode.pop_front(); eUnk = qUnk.pop_front();
        eCyc = qCyc.pop_front();  tag = qTag.pop_front();
        check(int'(hangCode) == eCode, tag, "hangCode", int'(hangCode), eCode);
        check(int'(unknownStable) == eUnk, tag, "unknownStable", int'(unknownStable), eUnk);
        check(cyc == eCyc, "R2", "done cycle", cyc, eCyc);
      end
    end
  end

  // driver: gSel 0 obs, 1..4 debug words 3..6; gAt = sample index to disturb
  task automatic runCheck(input logic [31:0] o, d3v, d4v, d5v, d6v,
                          input logic bbE, macE, input int gSel, input int gAt,
                          input int poke, input int eCode, input int eUnk,
                          input string tag);
    @(negedge clk);
    obsWord = o; dbgWord3 = d3v; dbgWord4 = d4v; dbgWord5 = d5v; dbgWord6 = d6v;
    bbCheckEn = bbE; macCheckEn = macE; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    qCode.push_back(eCode); qUnk.push_back(eUnk);
    qCyc.push_back(cyc + NREADS + 1); qTag.push_back(tag);
    for (int j = 1; j <= NREADS + 2; j++) begin
      obsWord = o; dbgWord3 = d3v; dbgWord4 = d4v; dbgWord5 = d5v; dbgWord6 = d6v;
      if (j == gAt) begin
        case (gSel)
          0: obsWord  = o ^ 32'h0000_0100;
          1: dbgWord3 = d3v ^ 32'h1;
          2: dbgWord4 = d4v ^ 32'h1;
          3: dbgWord5 = d5v ^ 32'h1;
          default: dbgWord6 = d6v ^ 32'h2;
        endcase
      end
      startReq = (j == poke);
      @(negedge clk);
    end
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(hangCode) == eCode, "R11", {tag, " held code"}, int'(hangCode), eCode);
    check(qCode.size() == 0, "R3", "pending results", qCode.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(donePulse == 1'b0, "R1", "reset donePulse", int'(donePulse), 0);
    check(hangCode == 3'd0, "R1", "reset hangCode", int'(hangCode), 0);
    check(unknownStable == 1'b0, "R1", "reset unknownStable", int'(unknownStable), 0);

    // R5 baseband patterns in order
    runCheck(32'h1E00_0000, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 0, "R5 dfs");
    runCheck(32'hD200_0B01, 0, 0, 0, 0, 1, 1, 0, 0, 0, 2, 0, "R5 rifs");
    runCheck(32'h1800_0B00, 0, 0, 0, 0, 1, 0, 0, 0, 0, 3, 0, "R5 rxclr");
    runCheck(32'h0070_2410, 0, 0, 0, 0, 1, 0, 0, 0, 0, 3, 0, "R5 rxclr2");
    // R4 last-sample glitch on baseband
    runCheck(32'h1E00_0000, 0, 0, 0, 0, 1, 0, 0, NREADS, 0, 0, 0, "R4 last");
    // R6 chain field in word 4 slot 5, and word 5 slot 3
    runCheck(0, 0, 32'h0C00_0000, 0, 32'h1, 1, 1, 0, 0, 0, 4, 0, "R6 d4");
    runCheck(0, 0, 0, 32'h0003_0000, 32'h5, 1, 1, 0, 0, 0, 4, 0, "R6 d5");
    // R10 completion bits wrong -> stable, unknown
    runCheck(0, 0, 32'h0C00_0000, 0, 32'h2, 1, 1, 0, 0, 0, 0, 1, "R10 nosig");
    // R7 signature 2, then both signatures -> 1 wins
    runCheck(0, 32'h1224_0000, 0, 0, 0, 0, 1, 0, 0, 0, 5, 0, "R7 sig2");
    runCheck(0, 32'h1224_0000, 32'h6, 0, 32'h1, 0, 1, 0, 0, 0, 4, 0, "R7 both");
    // R8 baseband hang suppresses MAC
    runCheck(32'h1E00_0000, 0, 32'h6, 0, 32'h1, 1, 1, 0, 0, 0, 1, 0, "R8 suppress");
    // R9 enables
    runCheck(32'h1E00_0000, 32'h1224_0000, 0, 0, 0, 0, 1, 0, 0, 0, 5, 0, "R9 bboff");
    runCheck(32'h1E00_0000, 0, 32'h6, 0, 32'h1, 0, 0, 0, 0, 0, 0, 0, "R9 alloff");
    runCheck(0, 0, 32'h6, 0, 32'h1, 0, 1, 0, 7, 0, 4, 0, "R9 glitch ignored");
    // R4 MAC instability on first sample
    runCheck(0, 0, 32'h6, 0, 32'h1, 1, 1, 4, 1, 0, 0, 1, "R4 mac glitch");
    // R3 start request mid-window
    runCheck(0, 32'h1224_0000, 0, 0, 0, 0, 1, 0, 0, 20, 5, 0, "R3 poke");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      summary();
      $finish;
    end
  end

endmodule